// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Front-End

This block is the digital input side of a two-channel 12-bit converter. A host shifts 14-bit frames over a serial clock and data line. The frames are qualified by an active-low chip select. Each frame carries a two-bit channel address followed by a twelve-bit straight-binary code, both most significant bit first. The frame collects in a shift register. Two channel registers hold the codes that feed the converter ladders, so a new frame can be shifted without disturbing the codes already presented.

An active-low load strobe moves the shift register contents into the addressed channel register. The channel register is level-sensitive: while the strobe is held low it stays open. Any further shifting during that time therefore ripples into the outputs bit by bit. The serial inputs are sampled by the system clock, and a rising edge on the serial clock is detected there.

Top module: `dac_fe_top`

## Requirements
- R1: A frame is 14 serial bits. The first 2 bits shifted form the channel address and the last 12 bits form the code. Address 01 selects channel A (`code_a_o`) and address 10 selects channel B (`code_b_o`).
- R2: Address and code are both shifted most significant bit first. A frame with address 01 and code 001h places 001h on `code_a_o` once it is loaded.
- R3: Codes pass to the outputs unchanged in straight binary, including the zero-scale, midscale and full-scale values 000h, 800h and FFFh.
- R4: While `load_ni` stays high, shifting a frame leaves both outputs unchanged.
- R5: A high-to-low transition of `load_ni` copies the 12 code bits in the shift register into the addressed channel register.
- R6: While `cs_ni` is high, serial clock edges are ignored and the shift register keeps its contents.
- R7: Address values 00 and 11 select no channel, and both outputs keep their values through a load.
- R8: After an asynchronous reset both outputs read 000h.
- R9: While `load_ni` is low the addressed channel register stays open, so each bit shifted in changes its output from the current shift register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the serial inputs |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; data is taken on its rising edge |
| sdi_i | input | 1 | Serial data |
| cs_ni | input | 1 | Active-low chip select that qualifies the serial clock |
| load_ni | input | 1 | Active-low load strobe; the addressed register is open while it is low |
| code_a_o | output | 12 | Code held for channel A |
| code_b_o | output | 12 | Code held for channel B |

## Verification
The hardest state to reach is shifting while the load strobe is already low. In that state the address bits move through the shift register during the frame, so the selected channel can change part way through and both registers can pick up intermediate values. The stimulus reaches this state in two ways. A directed pass holds the strobe low across a whole frame and checks both outputs after every bit. A seeded random phase also drops the strobe at random points within frames and toggles chip select at random. It is checked against a bench model that tracks the shift register and both channel registers bit by bit.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  localparam int CODE_W = 12;
  localparam int SEL_W  = 2;
  localparam int CH_N   = 2;
endpackage

// File: rtl/dac_fe_sampler.sv
module dac_fe_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sdi_i,
  input  logic cs_ni,
  input  logic load_ni,
  output logic shift_en_o,
  output logic sdi_o,
  output logic cs_idle_o,
  output logic load_lvl_o
);
  logic sclk_q, sclk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q      <= 1'b0;
      sclk_prev_q <= 1'b0;
      sdi_o       <= 1'b0;
      cs_idle_o   <= 1'b1;
      load_lvl_o  <= 1'b1;
    end else begin
      sclk_q      <= sclk_i;
      sclk_prev_q <= sclk_q;
      sdi_o       <= sdi_i;
      cs_idle_o   <= cs_ni;
      load_lvl_o  <= load_ni;
    end
  end

  // rising serial clock edge, only while selected
  assign shift_en_o = sclk_q & ~sclk_prev_q & ~cs_idle_o;
endmodule

// File: rtl/dac_fe_shreg.sv
module dac_fe_shreg #(
  parameter int FRAME_W = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_en_i,
  input  logic               sdi_i,
  output logic [FRAME_W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         word_o <= '0;
    else if (shift_en_i) word_o <= {word_o[FRAME_W-2:0], sdi_i};
  end
endmodule

// File: rtl/dac_fe_chreg.sv
module dac_fe_chreg #(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 2,
  parameter int SEL    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] code_o
);
  localparam logic [ADDR_W-1:0] SelCode = ADDR_W'(SEL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           code_o <= '0;
    else if (open_i && addr_i == SelCode)  code_o <= data_i;
  end
endmodule

// File: rtl/dac_fe_top.sv
module dac_fe_top #(
  parameter int DATA_W = dac_fe_pkg::CODE_W,
  parameter int ADDR_W = dac_fe_pkg::SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              cs_ni,
  input  logic              load_ni,
  output logic [DATA_W-1:0] code_a_o,
  output logic [DATA_W-1:0] code_b_o
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CH_N    = dac_fe_pkg::CH_N;

  logic               shift_en, sdi_lvl, cs_idle, load_lvl;
  logic [FRAME_W-1:0] shift_word;
  logic [DATA_W-1:0]  code_q [CH_N];

  dac_fe_sampler i_sampler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (sclk_i),
    .sdi_i      (sdi_i),
    .cs_ni      (cs_ni),
    .load_ni    (load_ni),
    .shift_en_o (shift_en),
    .sdi_o      (sdi_lvl),
    .cs_idle_o  (cs_idle),
    .load_lvl_o (load_lvl)
  );

  dac_fe_shreg #(.FRAME_W(FRAME_W)) i_shreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_en),
    .sdi_i      (sdi_lvl),
    .word_o     (shift_word)
  );

  // channel k answers to address k+1; other codes select nothing
  for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
    dac_fe_chreg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL(ch + 1)) i_chreg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .open_i (~load_lvl),
      .addr_i (shift_word[FRAME_W-1 -: ADDR_W]),
      .data_i (shift_word[DATA_W-1:0]),
      .code_o (code_q[ch])
    );
  end

  assign code_a_o = code_q[0];
  assign code_b_o = code_q[1];
endmodule

// File: rtl/dac_fe_chk.sv
module dac_fe_chk #(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     load_lvl_i,
  input logic                     cs_idle_i,
  input logic [ADDR_W+DATA_W-1:0] shift_i,
  input logic [DATA_W-1:0]        code_a_i,
  input logic [DATA_W-1:0]        code_b_i
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  logic [ADDR_W-1:0] addr;
  assign addr = shift_i[FRAME_W-1 -: ADDR_W];

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_lvl_i |=> ($stable(code_a_i) && $stable(code_b_i)));

  // covers R9 as well: open register follows shift contents
  p_xfer_a_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_lvl_i && addr == ADDR_W'(1)) |=> code_a_i == $past(shift_i[DATA_W-1:0]));

  p_xfer_b_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_lvl_i && addr == ADDR_W'(2)) |=> code_b_i == $past(shift_i[DATA_W-1:0]));

  p_cs_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_idle_i |=> $stable(shift_i));

  p_bad_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr == ADDR_W'(0) || addr == ADDR_W'(3)) |=> ($stable(code_a_i) && $stable(code_b_i)));

  p_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (code_a_i == '0 && code_b_i == '0));
endmodule

bind dac_fe_top dac_fe_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_lvl_i (load_lvl),
  .cs_idle_i  (cs_idle),
  .shift_i    (shift_word),
  .code_a_i   (code_a_o),
  .code_b_i   (code_b_o)
);

// File: tb/test_dac_fe_top.sv
module test_dac_fe_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, load_n = 1'b1;
  logic [11:0] code_a, code_b;

  int checks = 0, errors = 0;
  logic [13:0] sh_m = '0;
  logic [11:0] ca_m = '0, cb_m = '0;
  logic load_m = 1'b1, cs_m = 1'b1;

  always #2 clk = ~clk;

  dac_fe_top i_dac_fe_top (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdi_i(sdi),
    .cs_ni(cs_n), .load_ni(load_n), .code_a_o(code_a), .code_b_o(code_b)
  );

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  // open register follows shift contents (R5, R9)
  task automatic model_open();
    if (!load_m) begin
      if (sh_m[13:12] == 2'b01)      ca_m = sh_m[11:0];
      else if (sh_m[13:12] == 2'b10) cb_m = sh_m[11:0];
    end
  endtask

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %03h expected %03h", tag, act, exp);
    end
  endtask

  task automatic chk_both(input string tag);
    chk({tag, " chA"}, code_a, ca_m);
    chk({tag, " chB"}, code_b, cb_m);
  endtask

  task automatic clk_bit(input logic b);
    sdi = b;
    settle();
    sclk = 1'b1;
    if (!cs_m) sh_m = {sh_m[12:0], b};
    model_open();
    settle();
    sclk = 1'b0;
    settle();
  endtask

  task automatic send(input logic [1:0] a, input logic [11:0] d, input bit each, input string tag);
    logic [13:0] fr;
    fr = {a, d};
    for (int i = 13; i >= 0; i--) begin
      clk_bit(fr[i]);
      if (each) chk_both(tag);
    end
  endtask

  task automatic set_load(input logic v);
    load_n = v; load_m = v;
    model_open();
    settle();
  endtask

  task automatic set_cs(input logic v);
    cs_n = v; cs_m = v;
    settle();
  endtask

  task automatic pulse_load();
    set_load(1'b0);
    set_load(1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1bad_5eed));
    repeat (3) @(negedge clk);
    chk_both("R8 in reset");
    rst_n = 1'b1;
    settle();
    chk_both("R8 after reset");
    set_cs(1'b0);

    // R1 R4: frame for A, outputs hold until load
    send(2'b01, 12'h800, 1'b1, "R4 hold while shifting");
    pulse_load();
    chk(" R1 R5 midscale to A", code_a, 12'h800);
    chk("R1 B untouched", code_b, 12'h000);

    send(2'b10, 12'hFFF, 1'b0, "");
    chk_both("R4 hold after frame");
    pulse_load();
    chk("R3 R5 full scale to B", code_b, 12'hFFF);
    chk("R5 A keeps value", code_a, 12'h800);

    // R2 MSB first
    send(2'b01, 12'h001, 1'b0, "");
    pulse_load();
    chk("R2 msb first", code_a, 12'h001);

    // R7 ignored addresses
    send(2'b00, 12'h5A5, 1'b0, "");
    pulse_load();
    chk_both("R7 addr 00 ignored");
    send(2'b11, 12'hA5A, 1'b0, "");
    pulse_load();
    chk_both("R7 addr 11 ignored");

    // R6 clocks ignored while deselected
    send(2'b01, 12'h123, 1'b0, "");
    set_cs(1'b1);
    send(2'b10, 12'hABC, 1'b0, "");
    set_cs(1'b0);
    pulse_load();
    chk("R6 deselected clocks ignored A", code_a, 12'h123);
    chk("R6 deselected clocks ignored B", code_b, 12'hFFF);

    // R3 zero scale
    send(2'b10, 12'h000, 1'b0, "");
    pulse_load();
    chk("R3 zero scale to B", code_b, 12'h000);

    // R9 transparent ripple, strobe low across a whole frame
    send(2'b01, 12'h800, 1'b0, "");
    set_load(1'b0);
    chk_both("R9 open at strobe fall");
    send(2'b01, 12'h555, 1'b1, "R9 ripple");
    chk("R9 final ripple value", code_a, 12'h555);
    set_load(1'b1);
    send(2'b10, 12'h3C3, 1'b1, "R9 closed after strobe rise");

    // random phase
    for (int f = 0; f < 40; f++) begin
      logic [1:0]  a;
      logic [11:0] d;
      logic [13:0] fr;
      int drop;
      a = 2'($urandom_range(0, 3));
      d = 12'($urandom);
      fr = {a, d};
      drop = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 13) : 99;
      if ($urandom_range(0, 7) == 0) set_cs(1'b1);
      for (int i = 13; i >= 0; i--) begin
        if (13 - i == drop) set_load(1'b0);
        clk_bit(fr[i]);
        chk_both("R9 R4 random bit");
      end
      if (cs_m) set_cs(1'b0);
      if (load_m) begin
        set_load(1'b0);
        chk_both("R5 R7 random load");
      end
      set_load(1'b1);
      chk_both("R4 random after load");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule